// File: doc/BRIEF.md
# Configurable Distributed LUT RAM

This block is a small single-port memory built from two 16-entry bit tables. Writes are synchronous and reads are asynchronous. A static organisation input picks one of two layouts. In the narrow layout, both tables share a 4-bit address and each table stores its own data bit. In the wide layout, the two tables form one 32x1 memory, and the second data pin becomes the fifth address bit.

A write takes place only at the active write edge, and only if the write enable is high. Address, data and enable are all sampled on that same edge. A parameter sets the write edge to rising or falling, and the choice applies to both tables. The table outputs follow the address combinationally.

A registered copy of the two read bits is also provided. Its clock edge is either the write edge or the opposite edge. A third output applies an 8-entry truth table to the two read bits and one spare input.

Top module: `lut_ram_cell`

## Requirements
- R1: With `mode_wide`=0, a write stores `d0` into the lower table and `d1` into the upper table, both at entry `addr`.
- R2: With `mode_wide`=1, `d1` is the fifth address bit. A value of 0 selects the lower table and 1 selects the upper table. Only the selected table is written, with `d0`, and `f_out` shows the entry from the selected table.
- R3: When `we` is 0 at the write edge, neither table changes.
- R4: `WR_NEG`=0 makes the rising clock edge the write edge for both tables. `WR_NEG`=1 makes it the falling edge.
- R5: `f_out` and `g_out` follow `addr`, `d1` and `mode_wide` without waiting for a clock edge. `g_out` is always the upper table entry at `addr`.
- R6: `fq`/`gq` capture `f_out`/`g_out`. With `OREG_OPP`=0 they capture on the write edge and get the value from before the write. With `OREG_OPP`=1 they capture on the opposite edge.
- R7: `h_out` equals bit {`spare`,`g_out`,`f_out`} of `h_tt`. In that index, `spare` is bit 2 and `f_out` is bit 0.
- R8: While reset is active, the lower table holds `INIT_LO` and the upper table holds `INIT_HI`, with bit i giving entry i. During reset, `fq` and `gq` are 0.
- R9: When two writes to the same entry come back to back, the second write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for writes and for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wide | input | 1 | Static organisation: 0 for 16x2, 1 for 32x1 |
| we | input | 1 | Active-high write enable |
| addr | input | AW | Entry address shared by both tables |
| d0 | input | 1 | Lower-table data; the only write data in 32x1 |
| d1 | input | 1 | Upper-table data in 16x2; fifth address bit in 32x1 |
| spare | input | 1 | Extra input to the third function |
| h_tt | input | 8 | Truth table of the third function |
| f_out | output | 1 | Asynchronous read, lower table or selected half |
| g_out | output | 1 | Asynchronous read, upper table |
| h_out | output | 1 | Third function output |
| fq | output | 1 | Registered `f_out` |
| gq | output | 1 | Registered `g_out` |

## Verification
Two instances run side by side on the same inputs. One writes on the rising edge and registers on that same edge. The other writes on the falling edge and registers on the opposite edge. A mismatch between them therefore shows up as an edge or capture-order fault.

Random address, data and enable traffic runs in each organisation. In 16x2 it separates correct per-table data from swapped or merged data. In 32x1 it shows whether the fifth address bit steers both the write and the read.

Directed cases check the reset contents across all entries, enable-low writes, and back-to-back writes to one entry. A check between the two clock edges shows whether the falling-edge instance has already written.

// File: rtl/lut_ram_pkg.sv
package lut_ram_pkg;

  typedef enum logic {
    ORG_NARROW = 1'b0,
    ORG_WIDE   = 1'b1
  } org_e;

  // three-input lookup: index is {spare, upper, lower}
  function automatic logic tt3_eval(input logic [7:0] tt, input logic s,
                                    input logic u, input logic l);
    logic [2:0] idx;
    idx = {s, u, l};
    return tt[idx];
  endfunction

endpackage

// File: rtl/lut_rst_sync.sv
module lut_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ni = sync_q[1];
endmodule

// File: rtl/lut_table16.sv
module lut_table16 #(
  parameter int               AW       = 4,
  parameter int               DEPTH    = 1 << AW,
  parameter logic [DEPTH-1:0] INIT     = '0,
  parameter bit               NEG_EDGE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             wen,
  input  logic [AW-1:0]    addr,
  input  logic             wdata,
  output logic             rdata,
  output logic [DEPTH-1:0] bits
);
  logic [DEPTH-1:0] mem_q;
  logic [DEPTH-1:0] mem_d;

  always_comb begin
    mem_d = mem_q;
    if (wen) mem_d[addr] = wdata;
  end

  generate
    if (NEG_EDGE) begin : g_fall
      always_ff @(negedge clk or negedge rst_ni) begin
        if (!rst_ni) mem_q <= INIT;
        else         mem_q <= mem_d;
      end
    end else begin : g_rise
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) mem_q <= INIT;
        else         mem_q <= mem_d;
      end
    end
  endgenerate

  assign rdata = mem_q[addr];
  assign bits  = mem_q;
endmodule

// File: rtl/lut_oreg.sv
module lut_oreg #(
  parameter int W        = 2,
  parameter bit NEG_EDGE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;

  generate
    if (NEG_EDGE) begin : g_fall
      always_ff @(negedge clk or negedge rst_ni) begin
        if (!rst_ni) q_r <= '0;
        else         q_r <= d;
      end
    end else begin : g_rise
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) q_r <= '0;
        else         q_r <= d;
      end
    end
  endgenerate

  assign q = q_r;
endmodule

// File: rtl/lut_ram_cell.sv
module lut_ram_cell #(
  parameter int               AW       = 4,
  parameter int               DEPTH    = 1 << AW,
  parameter logic [DEPTH-1:0] INIT_LO  = '0,
  parameter logic [DEPTH-1:0] INIT_HI  = '0,
  parameter bit               WR_NEG   = 1'b0,
  parameter bit               OREG_OPP = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_wide,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic          d0,
  input  logic          d1,
  input  logic          spare,
  input  logic [7:0]    h_tt,
  output logic          f_out,
  output logic          g_out,
  output logic          h_out,
  output logic          fq,
  output logic          gq
);
  import lut_ram_pkg::*;

  localparam bit OREG_NEG = WR_NEG ^ OREG_OPP;

  logic             rst_ni;
  org_e             org;
  logic             wen_lo, wen_hi;
  logic             wd_hi;
  logic             rd_lo, rd_hi;
  logic [DEPTH-1:0] lo_bits, hi_bits;
  logic [1:0]       oreg_q;

  lut_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  assign org = org_e'(mode_wide);

  // write steering: in wide mode d1 is the half select
  always_comb begin
    wen_lo = we;
    wen_hi = we;
    wd_hi  = d1;
    if (org == ORG_WIDE) begin
      wen_lo = we & ~d1;
      wen_hi = we &  d1;
      wd_hi  = d0;
    end
  end

  lut_table16 #(.AW(AW), .DEPTH(DEPTH), .INIT(INIT_LO), .NEG_EDGE(WR_NEG)) u_lo (
    .clk    (clk),
    .rst_ni (rst_ni),
    .wen    (wen_lo),
    .addr   (addr),
    .wdata  (d0),
    .rdata  (rd_lo),
    .bits   (lo_bits)
  );

  lut_table16 #(.AW(AW), .DEPTH(DEPTH), .INIT(INIT_HI), .NEG_EDGE(WR_NEG)) u_hi (
    .clk    (clk),
    .rst_ni (rst_ni),
    .wen    (wen_hi),
    .addr   (addr),
    .wdata  (wd_hi),
    .rdata  (rd_hi),
    .bits   (hi_bits)
  );

  always_comb begin
    f_out = rd_lo;
    if (org == ORG_WIDE && d1) f_out = rd_hi;
  end

  assign g_out = rd_hi;
  assign h_out = tt3_eval(h_tt, spare, g_out, f_out);

  lut_oreg #(.W(2), .NEG_EDGE(OREG_NEG)) u_oreg (
    .clk    (clk),
    .rst_ni (rst_ni),
    .d      ({g_out, f_out}),
    .q      (oreg_q)
  );

  assign fq = oreg_q[0];
  assign gq = oreg_q[1];
endmodule

// File: rtl/lut_ram_cell_chk.sv
module lut_ram_cell_chk #(
  parameter int AW     = 4,
  parameter int DEPTH  = 1 << AW,
  parameter bit WR_NEG = 1'b0
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             mode_wide,
  input logic             we,
  input logic [AW-1:0]    addr,
  input logic             d0,
  input logic             d1,
  input logic [DEPTH-1:0] lo_bits,
  input logic [DEPTH-1:0] hi_bits
);
  logic wclk;
  assign wclk = WR_NEG ? ~clk : clk;

  p_we_low_hold_r3: assert property (@(posedge wclk) disable iff (!rst_ni)
    !we |=> ($stable(lo_bits) && $stable(hi_bits)));

  p_narrow_write_r1: assert property (@(posedge wclk) disable iff (!rst_ni)
    (!mode_wide && we) |=>
      (lo_bits[$past(addr)] == $past(d0) && hi_bits[$past(addr)] == $past(d1)));

  p_wide_lower_only_r2: assert property (@(posedge wclk) disable iff (!rst_ni)
    (mode_wide && we && !d1) |=>
      ($stable(hi_bits) && lo_bits[$past(addr)] == $past(d0)));

  p_wide_upper_only_r2: assert property (@(posedge wclk) disable iff (!rst_ni)
    (mode_wide && we && d1) |=>
      ($stable(lo_bits) && hi_bits[$past(addr)] == $past(d0)));
endmodule

bind lut_ram_cell lut_ram_cell_chk #(.AW(AW), .DEPTH(DEPTH), .WR_NEG(WR_NEG)) u_chk (
  .clk       (clk),
  .rst_ni    (rst_ni),
  .mode_wide (mode_wide),
  .we        (we),
  .addr      (addr),
  .d0        (d0),
  .d1        (d1),
  .lo_bits   (lo_bits),
  .hi_bits   (hi_bits)
);

// File: tb/sim_lut_ram_cell.sv
module sim_lut_ram_cell;
  localparam logic [15:0] ILO = 16'hA5C3;
  localparam logic [15:0] IHI = 16'h0FF0;

  logic clk = 1'b0;
  logic rst_n, mode_wide, we, d0, d1, spare;
  logic [3:0] addr;
  logic [7:0] h_tt;
  logic f0, g0, h0, fq0, gq0;
  logic f1, g1, h1, fq1, gq1;
  int   nchk = 0;
  int   nerr = 0;

  logic [15:0] m0_lo, m0_hi, m1_lo, m1_hi;

  always #5 clk = ~clk;

  // rising write, same-edge register
  lut_ram_cell #(.INIT_LO(ILO), .INIT_HI(IHI), .WR_NEG(1'b0), .OREG_OPP(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide), .we(we), .addr(addr),
    .d0(d0), .d1(d1), .spare(spare), .h_tt(h_tt),
    .f_out(f0), .g_out(g0), .h_out(h0), .fq(fq0), .gq(gq0));

  // falling write, opposite-edge register
  lut_ram_cell #(.INIT_LO(ILO), .INIT_HI(IHI), .WR_NEG(1'b1), .OREG_OPP(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide), .we(we), .addr(addr),
    .d0(d0), .d1(d1), .spare(spare), .h_tt(h_tt),
    .f_out(f1), .g_out(g1), .h_out(h1), .fq(fq1), .gq(gq1));

  function automatic logic exp_f(input logic [15:0] lo, input logic [15:0] hi);
    return (mode_wide && d1) ? hi[addr] : lo[addr];
  endfunction

  function automatic logic [15:0] next_lo(input logic [15:0] lo);
    logic [15:0] r;
    r = lo;
    if (we && !(mode_wide && d1)) r[addr] = d0;
    return r;
  endfunction

  function automatic logic [15:0] next_hi(input logic [15:0] hi);
    logic [15:0] r;
    r = hi;
    if (we && (!mode_wide || d1)) r[addr] = mode_wide ? d0 : d1;
    return r;
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk_comb(input string tag);
    logic ef0, eg0, ef1, eg1;
    ef0 = exp_f(m0_lo, m0_hi); eg0 = m0_hi[addr];
    ef1 = exp_f(m1_lo, m1_hi); eg1 = m1_hi[addr];
    chk(tag, "u0 f_out", f0, ef0);
    chk("R5", "u0 g_out", g0, eg0);
    chk("R7", "u0 h_out", h0, h_tt[{spare, eg0, ef0}]);
    chk(tag, "u1 f_out", f1, ef1);
    chk("R5", "u1 g_out", g1, eg1);
    chk("R7", "u1 h_out", h1, h_tt[{spare, eg1, ef1}]);
  endtask

  // entered 2 time units after a rising edge with inputs set
  task automatic run_cycle(input string tag);
    logic ef0, eg0, ef1, eg1;
    #1;
    chk_comb(tag);
    @(negedge clk);
    m1_lo = next_lo(m1_lo);
    m1_hi = next_hi(m1_hi);
    #1;
    chk("R4", "u1 f_out after falling edge", f1, exp_f(m1_lo, m1_hi));
    chk("R4", "u1 g_out after falling edge", g1, m1_hi[addr]);
    chk("R4", "u0 f_out unchanged at falling edge", f0, exp_f(m0_lo, m0_hi));
    @(posedge clk);
    ef0 = exp_f(m0_lo, m0_hi); eg0 = m0_hi[addr];
    ef1 = exp_f(m1_lo, m1_hi); eg1 = m1_hi[addr];
    m0_lo = next_lo(m0_lo);
    m0_hi = next_hi(m0_hi);
    #1;
    chk("R6", "u0 fq same edge", fq0, ef0);
    chk("R6", "u0 gq same edge", gq0, eg0);
    chk("R6", "u1 fq opposite edge", fq1, ef1);
    chk("R6", "u1 gq opposite edge", gq1, eg1);
    #1;
  endtask

  initial begin
    #(200000 * 10);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd1234);
    rst_n = 1'b0; mode_wide = 1'b0; we = 1'b0; d0 = 1'b0; d1 = 1'b0;
    spare = 1'b0; addr = '0; h_tt = 8'hE8;
    m0_lo = ILO; m0_hi = IHI; m1_lo = ILO; m1_hi = IHI;
    repeat (3) @(posedge clk);
    #2;
    // R8: reset contents and cleared registers
    for (int a = 0; a < 16; a++) begin
      addr = a[3:0];
      #1;
      chk("R8", "u0 lower init", f0, ILO[a]);
      chk("R8", "u0 upper init", g0, IHI[a]);
      chk("R8", "u1 lower init", f1, ILO[a]);
      chk("R8", "u1 upper init", g1, IHI[a]);
    end
    chk("R8", "u0 fq reset", fq0, 1'b0);
    chk("R8", "u0 gq reset", gq0, 1'b0);
    chk("R8", "u1 fq reset", fq1, 1'b0);
    chk("R8", "u1 gq reset", gq1, 1'b0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;

    // R3: enable low with new data leaves entries
    addr = 4'd3; d0 = ~ILO[3]; d1 = ~IHI[3]; we = 1'b0;
    run_cycle("R3");
    run_cycle("R3");

    // R9: back-to-back writes to one entry, narrow mode
    addr = 4'd5; we = 1'b1; d0 = 1'b1; d1 = 1'b0;
    run_cycle("R1");
    d0 = 1'b0; d1 = 1'b1;
    run_cycle("R9");
    we = 1'b0;
    run_cycle("R9");

    // R1: random narrow traffic
    for (int i = 0; i < 300; i++) begin
      we = $urandom; addr = $urandom; d0 = $urandom; d1 = $urandom;
      spare = $urandom;
      if (i % 50 == 0) h_tt = $urandom;
      run_cycle("R1");
    end

    // R2: wide mode, directed half select
    mode_wide = 1'b1; we = 1'b1; addr = 4'd9; d1 = 1'b0; d0 = ~m0_lo[9];
    run_cycle("R2");
    d1 = 1'b1; d0 = ~m0_hi[9];
    run_cycle("R2");
    we = 1'b0; d1 = 1'b0;
    run_cycle("R2");
    // R9 in wide mode
    we = 1'b1; d1 = 1'b1; addr = 4'd12; d0 = 1'b1;
    run_cycle("R2");
    d0 = 1'b0;
    run_cycle("R9");
    we = 1'b0;
    run_cycle("R9");

    // R2: random wide traffic
    for (int i = 0; i < 300; i++) begin
      we = $urandom; addr = $urandom; d0 = $urandom; d1 = $urandom;
      spare = $urandom;
      if (i % 50 == 0) h_tt = $urandom;
      run_cycle("R2");
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    if (seed_unused()) $display("unused");
  end

  function automatic bit seed_unused();
    return 1'b0;
  endfunction
endmodule